// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the software-visible register file of a general-purpose I/O port with up to 32 channels. A simple word-addressed bus reaches it. One request can be presented per cycle. A write takes effect at the clock edge that accepts it. A read returns its data one cycle later, together with a response strobe.

The bank holds the following state:
- the output levels and the per-channel output-enable (direction);
- the interrupt enable and the per-channel interrupt mode nibbles;
- the pull selection bits and the input-filter settings.

It drives all of this state straight out to the pad ring and to the neighbouring interrupt detector.

Output bits have three write paths: a full-word load, a set-only port and a clear-only port. Software can therefore change single pins without a read-modify-write.

Input levels pass through a two-flop synchronizer before software can read them. Interrupt status bits are raised by the external detector through a per-channel set input. Software clears them by writing ones. When a hardware set and a software clear land on the same bit in the same cycle, the set is kept.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, the following are all zero: output data, direction, interrupt enable, pull enable, pull select, filter enable, filter control, every mode register and the interrupt status. Because direction is zero, every channel starts as an input (`pin_oe` all zero).
- R2: The direction register at byte offset 0x28 reads back what was written. Bit c set to 1 makes channel c an output, so `pin_oe[c]` = 1 from the cycle after the write.
- R3: A write to offset 0x30 sets to 1 each output bit whose written bit is 1. Bits written with 0 keep their value.
- R4: A write to offset 0x2C clears to 0 each output bit whose written bit is 1. Bits written with 0 keep their value.
- R5: A write to offset 0x24 loads all output bits at once. A read of 0x24 returns the current output value, which is also driven on `pin_out`. Output bits change only through 0x24, 0x2C and 0x30.
- R6: Reads of offsets 0x2C and 0x30 return zero.
- R7: A read of offset 0x20 returns `pin_in` after two synchronizing flops. After `pin_in` changes, a read accepted on the first or second rising edge still returns the old level. A read accepted on the third edge returns the new level.
- R8: The interrupt enable register at 0x50 holds one bit per channel. It reads back what was written and drives `irq_en` from the next cycle.
- R9: Writing 1 to a bit of the interrupt status register at 0x64 clears that bit. Writing 0 leaves it unchanged.
- R10: If `stat_set[c]` is high in the same cycle as a write of 1 to status bit c, the bit ends up set.
- R11: A one-cycle pulse on `stat_set[c]` sets status bit c. The bit stays set until software clears it.
- R12: There are four mode registers, at 0x54, 0x58, 0x5C and 0x60. Channel c uses nibble c%8 of register c/8, and that nibble drives `int_mode[4c+3:4c]`.
  - The pull enable (0x40), pull select (0x44), filter enable (0x70) and filter control (0x74) registers read back what was written.
  - 0x00 returns the identification constant (default 0x67700100), and 0x10 returns the channel count.
  - Any other offset reads zero and ignores writes.
- R13: `rsp_valid` is high in exactly the cycle after each accepted read, with `rsp_rdata` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Output data to pads |
| pin_oe | output | 32 | Per-channel output enable |
| pull_en | output | 32 | Per-channel pull enable |
| pull_sel | output | 32 | Per-channel pull select |
| filt_en | output | 32 | Per-channel input filter enable |
| filt_ctl | output | 32 | Filter control word |
| irq_en | output | 32 | Per-channel interrupt enable |
| int_mode | output | 128 | Four mode bits per channel |
| stat_set | input | 32 | Status set pulses from the detector |
| irq_status | output | 32 | Interrupt status bits |

## Verification
A wrong internal state shows at the ports one cycle after it is created: output state appears directly on `pin_out` and `pin_oe`, and register contents are returned by the next read. A set or clear that disturbs neighbouring bits is caught by reading the output word back right after each strobe, using patterns whose untouched bits are non-zero. A synchronizer with the wrong depth moves the cycle in which the new input level is first returned, which three back-to-back reads pin down. A wrong priority between the hardware set and the software clear leaves the status bit at zero when it should read as one.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

    // Byte offsets decoded by the bank; software depends on these.
    localparam logic [7:0] OFS_ID       = 8'h00;
    localparam logic [7:0] OFS_HWCFG    = 8'h10;
    localparam logic [7:0] OFS_DIN      = 8'h20;
    localparam logic [7:0] OFS_DOUT     = 8'h24;
    localparam logic [7:0] OFS_DIR      = 8'h28;
    localparam logic [7:0] OFS_DCLR     = 8'h2C;
    localparam logic [7:0] OFS_DSET     = 8'h30;
    localparam logic [7:0] OFS_PULL_EN  = 8'h40;
    localparam logic [7:0] OFS_PULL_SEL = 8'h44;
    localparam logic [7:0] OFS_IRQ_EN   = 8'h50;
    localparam logic [7:0] OFS_MODE0    = 8'h54;
    localparam logic [7:0] OFS_IRQ_STAT = 8'h64;
    localparam logic [7:0] OFS_FILT_EN  = 8'h70;
    localparam logic [7:0] OFS_FILT_CTL = 8'h74;

    localparam int BUS_W        = 32;
    localparam int MODE_W       = 4;
    localparam int CH_PER_MODE  = BUS_W / MODE_W;

    typedef enum logic [1:0] {
        DOUT_HOLD = 2'd0,
        DOUT_LOAD = 2'd1,
        DOUT_SET  = 2'd2,
        DOUT_CLR  = 2'd3
    } dout_op_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

    // Edges seen since reset, saturating; gates the latency check.
    logic [1:0] warm_d, warm_q;

    always_comb begin
        warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else begin
            warm_q <= warm_d;
        end
    end

    generate
        if (STAGES == 2) begin : g_chk_two
            AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q >= 2'd2) |-> (sync_o == $past(async_i, 2))); // R7
        end
    endgenerate

endmodule

// File: rtl/gpio_out_ctl.sv
module gpio_out_ctl
    import gpio_regbank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dout_op_e     op_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] dout_o
);

    logic [W-1:0] dout_d, dout_q;

    always_comb begin
        dout_d = dout_q;
        unique case (op_i)
            DOUT_LOAD: dout_d = data_i;
            DOUT_SET:  dout_d = dout_q | data_i;
            DOUT_CLR:  dout_d = dout_q & ~data_i;
            default:   dout_d = dout_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign dout_o = dout_q;

    AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == DOUT_SET) |=> ((dout_o & $past(data_i)) == $past(data_i))); // R3
    AST_SET_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == DOUT_SET) |=> ((dout_o & ~$past(data_i)) == ($past(dout_o) & ~$past(data_i)))); // R3
    AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == DOUT_CLR) |=> ((dout_o & $past(data_i)) == '0)); // R4
    AST_CLR_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == DOUT_CLR) |=> ((dout_o & ~$past(data_i)) == ($past(dout_o) & ~$past(data_i)))); // R4
    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == DOUT_LOAD) |=> (dout_o == $past(data_i))); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == DOUT_HOLD) |=> $stable(dout_o)); // R5

endmodule

// File: rtl/gpio_stat_w1c.sv
module gpio_stat_w1c #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] stat_d, stat_q;

    always_comb begin
        // Clear first, then OR in the hardware set, so the set wins.
        stat_d = (stat_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i))); // R10
    AST_CLR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((stat_o & $past(clr_i & ~set_i)) == '0)); // R9
    AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((stat_o & ~$past(clr_i)) == ($past(stat_o) & ~$past(clr_i)))); // R9

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_regbank_pkg::*;
#(
    parameter int          NCH      = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] ID_VALUE = 32'h6770_0100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_rdata,
    input  logic [NCH-1:0]        pin_in,
    output logic [NCH-1:0]        pin_out,
    output logic [NCH-1:0]        pin_oe,
    output logic [NCH-1:0]        pull_en,
    output logic [NCH-1:0]        pull_sel,
    output logic [NCH-1:0]        filt_en,
    output logic [31:0]           filt_ctl,
    output logic [NCH-1:0]        irq_en,
    output logic [NCH*MODE_W-1:0] int_mode,
    input  logic [NCH-1:0]        stat_set,
    output logic [NCH-1:0]        irq_status
);

    localparam int MODE_REGS = (NCH + CH_PER_MODE - 1) / CH_PER_MODE;
    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic [NCH-1:0]                  dir;
        logic [NCH-1:0]                  irq_en;
        logic [NCH-1:0]                  pull_en;
        logic [NCH-1:0]                  pull_sel;
        logic [NCH-1:0]                  filt_en;
        logic [BUS_W-1:0]                filt_ctl;
        logic [MODE_REGS-1:0][BUS_W-1:0] mode;
        logic                            rvalid;
        logic [BUS_W-1:0]                rdata;
    } regs_t;

    regs_t          regs_d, regs_q;
    dout_op_e       dout_op;
    logic [NCH-1:0] stat_clr;
    logic [NCH-1:0] din_sync;
    logic [NCH-1:0] dout_cur;
    logic [NCH-1:0] stat_cur;
    logic [BUS_W-1:0] rd_mux;
    logic           wr_en, rd_en;

    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;

    gpio_in_sync #(
        .W      (NCH),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (din_sync)
    );

    gpio_out_ctl #(
        .W (NCH)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (dout_op),
        .data_i (req_wdata[NCH-1:0]),
        .dout_o (dout_cur)
    );

    gpio_stat_w1c #(
        .W (NCH)
    ) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (stat_set),
        .clr_i  (stat_clr),
        .stat_o (stat_cur)
    );

    // Read data selection by offset.
    always_comb begin
        rd_mux = '0;
        if (req_addr == ADDR_W'(OFS_ID)) begin
            rd_mux = ID_VALUE;
        end else if (req_addr == ADDR_W'(OFS_HWCFG)) begin
            rd_mux = BUS_W'(NCH);
        end else if (req_addr == ADDR_W'(OFS_DIN)) begin
            rd_mux = BUS_W'(din_sync);
        end else if (req_addr == ADDR_W'(OFS_DOUT)) begin
            rd_mux = BUS_W'(dout_cur);
        end else if (req_addr == ADDR_W'(OFS_DIR)) begin
            rd_mux = BUS_W'(regs_q.dir);
        end else if (req_addr == ADDR_W'(OFS_PULL_EN)) begin
            rd_mux = BUS_W'(regs_q.pull_en);
        end else if (req_addr == ADDR_W'(OFS_PULL_SEL)) begin
            rd_mux = BUS_W'(regs_q.pull_sel);
        end else if (req_addr == ADDR_W'(OFS_IRQ_EN)) begin
            rd_mux = BUS_W'(regs_q.irq_en);
        end else if (req_addr == ADDR_W'(OFS_IRQ_STAT)) begin
            rd_mux = BUS_W'(stat_cur);
        end else if (req_addr == ADDR_W'(OFS_FILT_EN)) begin
            rd_mux = BUS_W'(regs_q.filt_en);
        end else if (req_addr == ADDR_W'(OFS_FILT_CTL)) begin
            rd_mux = regs_q.filt_ctl;
        end
        for (int i = 0; i < MODE_REGS; i++) begin
            if (req_addr == ADDR_W'(int'(OFS_MODE0) + 4 * i)) begin
                rd_mux = regs_q.mode[i];
            end
        end
    end

    // Next-state computation for every held register.
    always_comb begin
        regs_d   = regs_q;
        dout_op  = DOUT_HOLD;
        stat_clr = '0;

        if (wr_en) begin
            if (req_addr == ADDR_W'(OFS_DOUT)) begin
                dout_op = DOUT_LOAD;
            end else if (req_addr == ADDR_W'(OFS_DSET)) begin
                dout_op = DOUT_SET;
            end else if (req_addr == ADDR_W'(OFS_DCLR)) begin
                dout_op = DOUT_CLR;
            end else if (req_addr == ADDR_W'(OFS_DIR)) begin
                regs_d.dir = req_wdata[NCH-1:0];
            end else if (req_addr == ADDR_W'(OFS_PULL_EN)) begin
                regs_d.pull_en = req_wdata[NCH-1:0];
            end else if (req_addr == ADDR_W'(OFS_PULL_SEL)) begin
                regs_d.pull_sel = req_wdata[NCH-1:0];
            end else if (req_addr == ADDR_W'(OFS_IRQ_EN)) begin
                regs_d.irq_en = req_wdata[NCH-1:0];
            end else if (req_addr == ADDR_W'(OFS_IRQ_STAT)) begin
                stat_clr = req_wdata[NCH-1:0];
            end else if (req_addr == ADDR_W'(OFS_FILT_EN)) begin
                regs_d.filt_en = req_wdata[NCH-1:0];
            end else if (req_addr == ADDR_W'(OFS_FILT_CTL)) begin
                regs_d.filt_ctl = req_wdata;
            end
            for (int i = 0; i < MODE_REGS; i++) begin
                if (req_addr == ADDR_W'(int'(OFS_MODE0) + 4 * i)) begin
                    regs_d.mode[i] = req_wdata;
                end
            end
        end

        regs_d.rvalid = rd_en;
        regs_d.rdata  = rd_en ? rd_mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rsp_valid  = regs_q.rvalid;
    assign rsp_rdata  = regs_q.rdata;
    assign pin_out    = dout_cur;
    assign pin_oe     = regs_q.dir;
    assign pull_en    = regs_q.pull_en;
    assign pull_sel   = regs_q.pull_sel;
    assign filt_en    = regs_q.filt_en;
    assign filt_ctl   = regs_q.filt_ctl;
    assign irq_en     = regs_q.irq_en;
    assign int_mode   = (NCH*MODE_W)'(regs_q.mode);
    assign irq_status = stat_cur;

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid); // R13
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid); // R13
    AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (req_addr == ADDR_W'(OFS_DSET) || req_addr == ADDR_W'(OFS_DCLR)))
        |=> (rsp_rdata == '0)); // R6
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == $past(req_wdata[NCH-1:0]))); // R2
    AST_IRQ_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_addr == ADDR_W'(OFS_IRQ_EN)) |=> (irq_en == $past(req_wdata[NCH-1:0]))); // R8
    AST_MODE0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_addr == ADDR_W'(OFS_MODE0)) |=> (int_mode[BUS_W-1:0] == $past(req_wdata))); // R12

endmodule

// File: tb/gpio_regbank_tb.sv
`timescale 1ns/1ps
module gpio_regbank_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic [31:0]  pin_in = '0;
    logic [31:0]  pin_out, pin_oe, pull_en, pull_sel, filt_en, filt_ctl, irq_en;
    logic [127:0] int_mode;
    logic [31:0]  stat_set = '0;
    logic [31:0]  irq_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_at_edge = 1'b0;

    always #2.5 clk = ~clk;

    gpio_regbank u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe),
        .pull_en (pull_en), .pull_sel (pull_sel), .filt_en (filt_en),
        .filt_ctl (filt_ctl), .irq_en (irq_en), .int_mode (int_mode),
        .stat_set (stat_set), .irq_status (irq_status)
    );

    function automatic void check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // Driver tasks: called just after a falling edge, return one cycle later.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_set(input logic [31:0] m);
        stat_set = m;
        @(negedge clk);
        stat_set = '0;
    endtask

    // Monitor: R13 timing of the response strobe, then scoreboard compare.
    always @(posedge clk) rd_at_edge <= rst_n && req_valid && !req_write;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid !== rd_at_edge) check("R13 rsp_valid timing", rsp_valid, rd_at_edge);
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check("R13 response without read", 1, 0);
                end else begin
                    check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_out", pin_out, 0);
        check("R1 pin_oe", pin_oe, 0);
        check("R1 irq_en", irq_en, 0);
        check("R1 int_mode", int_mode, 0);
        check("R1 irq_status", irq_status, 0);
        check("R1 pulls", {pull_en, pull_sel, filt_en, filt_ctl}, 0);
        rd(8'h24, 32'h0, "R1 dout reset");
        rd(8'h28, 32'h0, "R1 dir reset");

        // R2 direction
        wr(8'h28, 32'hF0F0_00FF);
        check("R2 pin_oe", pin_oe, 32'hF0F0_00FF);
        rd(8'h28, 32'hF0F0_00FF, "R2 dir readback");

        // R5 full-word load
        wr(8'h24, 32'h1234_5678);
        check("R5 pin_out", pin_out, 32'h1234_5678);
        rd(8'h24, 32'h1234_5678, "R5 dout readback");

        // R3 set port
        wr(8'h30, 32'h8000_0001);
        check("R3 pin_out after set", pin_out, 32'h9234_5679);
        wr(8'h30, 32'h0);
        rd(8'h24, 32'h9234_5679, "R3 zero set keeps");

        // R4 clear port
        wr(8'h2C, 32'h0000_0078);
        check("R4 pin_out after clear", pin_out, 32'h9234_5601);
        rd(8'h24, 32'h9234_5601, "R4 dout readback");

        // R6 strobe registers read zero
        rd(8'h30, 32'h0, "R6 set reg reads 0");
        rd(8'h2C, 32'h0, "R6 clr reg reads 0");

        // R7 synchronizer latency: reads on edges 1, 2, 3 after the change
        pin_in = 32'hA5A5_5A5A;
        rd(8'h20, 32'h0, "R7 first edge old");
        rd(8'h20, 32'h0, "R7 second edge old");
        rd(8'h20, 32'hA5A5_5A5A, "R7 third edge new");

        // R8 interrupt enable
        wr(8'h50, 32'h0000_FFFF);
        check("R8 irq_en port", irq_en, 32'h0000_FFFF);
        rd(8'h50, 32'h0000_FFFF, "R8 irq_en readback");

        // R11 sticky status from a one-cycle pulse
        pulse_set(32'h0000_0011);
        @(negedge clk);
        check("R11 status port", irq_status, 32'h11);
        rd(8'h64, 32'h11, "R11 status sticky");

        // R9 write-one-to-clear
        wr(8'h64, 32'h0000_0001);
        rd(8'h64, 32'h10, "R9 one clears");
        wr(8'h64, 32'h0);
        rd(8'h64, 32'h10, "R9 zero keeps");

        // R10 set beats clear in the same cycle
        stat_set = 32'h0000_0010;
        wr(8'h64, 32'h0000_0010);
        stat_set = '0;
        rd(8'h64, 32'h10, "R10 set wins");
        wr(8'h64, 32'h0000_0010);
        rd(8'h64, 32'h0, "R9 clear after race");

        // R12 mode, pull, filter, id and unmapped
        wr(8'h60, 32'h7650_0000);
        check("R12 mode reg3 nibbles", int_mode[127:96], 32'h7650_0000);
        wr(8'h54, 32'h0000_0003);
        check("R12 channel0 mode", int_mode[3:0], 4'h3);
        rd(8'h60, 32'h7650_0000, "R12 mode3 readback");
        wr(8'h40, 32'h0F0F_0F0F);
        wr(8'h44, 32'h0000_00F0);
        wr(8'h70, 32'h8000_0001);
        wr(8'h74, 32'h8000_0003);
        check("R12 pull/filter ports", {pull_en, pull_sel, filt_en, filt_ctl},
              {32'h0F0F_0F0F, 32'h0000_00F0, 32'h8000_0001, 32'h8000_0003});
        rd(8'h40, 32'h0F0F_0F0F, "R12 pull_en readback");
        rd(8'h44, 32'h0000_00F0, "R12 pull_sel readback");
        rd(8'h70, 32'h8000_0001, "R12 filt_en readback");
        rd(8'h74, 32'h8000_0003, "R12 filt_ctl readback");
        rd(8'h00, 32'h6770_0100, "R12 id");
        rd(8'h10, 32'd32, "R12 channel count");
        wr(8'h7C, 32'hFFFF_FFFF);
        rd(8'h7C, 32'h0, "R12 unmapped reads 0");
        rd(8'h24, 32'h9234_5601, "R12 unmapped write ignored dout");
        check("R12 unmapped write ignored oe", pin_oe, 32'hF0F0_00FF);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R13 missing responses", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule